// File: doc/BRIEF.md
# Prioritized System Reset Controller

This block decides which reset the chip goes through and for how long. It has six ranked reset causes. The lowest-level power-on reset arrives on the block's own asynchronous reset input. Test, external-pin warm, emulation warm and watchdog requests arrive on plain request lines. Software cold and warm requests are written into a small control register. When several causes are pending in the same cycle, only the highest-ranked one is accepted. The accepted cause then drives three reset domains for a fixed number of cycles:

- the full (cold) domain,
- the warm domain,
- the test-logic domain.

The block also keeps a 16-bit boot-mode word. Only the power-on and external-pin resets sample this word again, at their release. Every other cause keeps the word it already holds. The reset-out pin is released (output enable low) during power-on, pin and test resets. During emulation, watchdog and software resets the pin is driven to the level of bit 11 of the latched boot-mode word. A status register keeps one sticky bit per cause so software can find out why the chip was last reset.

While a sequence is running, a request of lower or equal rank is dropped. A request of higher rank restarts the full hold time under the new cause. The register port is a plain single-cycle write strobe with a combinational read. It has no handshake and is never stalled.

Top module: `sys_rst_mgr`

## Requirements
- R1: When several requests are accepted in the same cycle, only the highest-ranked one is taken. The ranks, highest first, are: power-on, test, external pin, emulation, watchdog, software. Between the two software requests, cold beats warm.
- R2: Domain outputs per accepted cause:
  - power-on: `cold_rst_o`, `warm_rst_o` and `tst_rst_o`;
  - test: only `tst_rst_o`;
  - pin, emulation, watchdog and software warm: only `warm_rst_o`;
  - software cold: `cold_rst_o` and `warm_rst_o`.
- R3: The domain outputs rise in the cycle that follows the accepting clock edge. They stay asserted for HOLD_CYC (16) cycles and fall together on the 16th edge after acceptance. After the release of `rst_n` they also stay asserted for 16 cycles.
- R4: Control register at address 0 (bit 0 = software cold, bit 1 = software warm). Writing 1 raises the request at the next edge. The bits clear themselves at that edge, so every later read of address 0 returns 0.
- R5: `boot_mode_o` takes the value of `boot_i` at the edge where a power-on or pin reset sequence ends. Sequences of any other cause leave it unchanged.
- R6: `rstout_oe_o` is 0 when idle and during power-on, pin and test sequences. During emulation, watchdog and software sequences it is 1, and `rstout_o` equals bit 11 of `boot_mode_o`.
- R7: Status register at address 1. Bit k is set when cause k is accepted (0 power-on, 1 test, 2 pin, 3 emulation, 4 watchdog, 5 software cold, 6 software warm). Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R8: A power-on reset (`rst_n` low) leaves the status register equal to 1: only bit 0 is set and all others are cleared.
- R9: A request of lower or equal rank that arrives during a running sequence is dropped. It sets no status bit and does not change the release cycle.
- R10: A higher-ranked request during a running sequence takes over at once. The domain outputs switch to the new cause, its status bit is set, and the release comes 16 cycles after this new acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| test_req_i | input | 1 | Test-logic reset request |
| pin_req_i | input | 1 | External warm reset pin request (synchronised) |
| emu_req_i | input | 1 | Emulation warm reset request |
| wdt_req_i | input | 1 | Watchdog reset request |
| boot_i | input | 16 | Boot-mode strap inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address (0 control, 1 status) |
| reg_wdata_i | input | 7 | Register write data |
| reg_rdata_o | output | 7 | Register read data for `reg_addr_i` |
| cold_rst_o | output | 1 | Cold (full) domain reset, active high |
| warm_rst_o | output | 1 | Warm domain reset, active high |
| tst_rst_o | output | 1 | Test-logic domain reset, active high |
| rstout_o | output | 1 | Reset-out pin level when driven |
| rstout_oe_o | output | 1 | Reset-out pin output enable (0 = high impedance) |
| boot_mode_o | output | 16 | Latched boot-mode word |

## Verification
The hardest case to reach is a software request meeting hardware requests in the same arbitration cycle. A software request passes through the control register first, so it reaches the arbiter one edge after it is written. The stimulus therefore writes the control register one cycle before it pulses the hardware lines, and both then reach the arbiter together. Requests that arrive in the middle of a sequence are placed by counting negative edges from the acceptance edge. This lets the bench check the takeover cycle and the exact release cycle, for both a dropped lower-ranked request and a higher-ranked takeover.

// File: rtl/rstm_pkg.sv
package rstm_pkg;

  typedef enum logic [2:0] {
    CS_POR  = 3'd0,
    CS_TEST = 3'd1,
    CS_PIN  = 3'd2,
    CS_EMU  = 3'd3,
    CS_WDT  = 3'd4,
    CS_SWC  = 3'd5,
    CS_SWW  = 3'd6
  } cause_e;

  localparam int NUM_CAUSE = 7;
  localparam int REG_W     = NUM_CAUSE;
  localparam int CTRL_COLD = 0;
  localparam int CTRL_WARM = 1;

  typedef struct packed {
    logic cold;
    logic warm;
    logic tst;
    logic pin_hiz;
    logic relatch;
  } dom_t;

  // Both software causes share the lowest rank.
  function automatic logic [2:0] rank_of(cause_e c);
    return (c == CS_SWW) ? 3'd5 : 3'(c);
  endfunction

  function automatic dom_t domains_of(cause_e c);
    dom_t d;
    d = '0;
    unique case (c)
      CS_POR:  d = '{cold: 1'b1, warm: 1'b1, tst: 1'b1, pin_hiz: 1'b1, relatch: 1'b1};
      CS_TEST: d = '{cold: 1'b0, warm: 1'b0, tst: 1'b1, pin_hiz: 1'b1, relatch: 1'b0};
      CS_PIN:  d = '{cold: 1'b0, warm: 1'b1, tst: 1'b0, pin_hiz: 1'b1, relatch: 1'b1};
      CS_SWC:  d = '{cold: 1'b1, warm: 1'b1, tst: 1'b0, pin_hiz: 1'b0, relatch: 1'b0};
      default: d = '{cold: 1'b0, warm: 1'b1, tst: 1'b0, pin_hiz: 1'b0, relatch: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rstm_arb.sv
module rstm_arb
  import rstm_pkg::*;
(
  input  logic [NUM_CAUSE-1:1] req_i,
  output logic                 vld_o,
  output cause_e               cause_o
);
  // Scan from the lowest rank upward; the last hit is the highest rank.
  always_comb begin
    vld_o   = 1'b0;
    cause_o = CS_SWW;
    for (int i = NUM_CAUSE - 1; i >= 1; i--) begin
      if (req_i[i]) begin
        vld_o   = 1'b1;
        cause_o = cause_e'(i);
      end
    end
  end
endmodule

// File: rtl/rstm_seq.sv
module rstm_seq
  import rstm_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_vld_i,
  input  cause_e req_cause_i,
  output logic   busy_o,
  output cause_e cause_o,
  output logic   accept_o,
  output logic   done_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

  logic             busy_q;
  cause_e           cause_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_cyc;

  assign last_cyc = busy_q && (cnt_q == '0);
  assign accept_o = req_vld_i &&
                    (!busy_q || last_cyc || (rank_of(req_cause_i) < rank_of(cause_q)));
  assign done_o   = last_cyc && !accept_o;
  assign busy_o   = busy_q;
  assign cause_o  = cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b1;
      cause_q <= CS_POR;
      cnt_q   <= CNT_LOAD;
    end else if (accept_o) begin
      busy_q  <= 1'b1;
      cause_q <= req_cause_i;
      cnt_q   <= CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rstm_regs.sv
module rstm_regs
  import rstm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             accept_i,
  input  cause_e           cause_i,
  output logic             swc_req_o,
  output logic             sww_req_o
);
  logic [1:0]           pend_q;
  logic [NUM_CAUSE-1:0] stat_q;
  logic [NUM_CAUSE-1:0] stat_d;

  // Software request bits live for one cycle: they are consumed or dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend_q <= '0;
    else if (wr_i && !addr_i)   pend_q <= {wdata_i[CTRL_WARM], wdata_i[CTRL_COLD]};
    else                        pend_q <= '0;
  end

  always_comb begin
    stat_d = stat_q;
    if (wr_i && addr_i) stat_d = stat_d & ~wdata_i[NUM_CAUSE-1:0];
    if (accept_i)       stat_d[cause_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= NUM_CAUSE'(1);
    else        stat_q <= stat_d;
  end

  assign swc_req_o = pend_q[0];
  assign sww_req_o = pend_q[1];
  assign rdata_o   = addr_i ? stat_q : {{(REG_W-2){1'b0}}, pend_q[1], pend_q[0]};
endmodule

// File: rtl/sys_rst_mgr.sv
module sys_rst_mgr
  import rstm_pkg::*;
#(
  parameter int HOLD_CYC   = 16,
  parameter int BOOT_W     = 16,
  parameter int RSTOUT_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_req_i,
  input  logic              pin_req_i,
  input  logic              emu_req_i,
  input  logic              wdt_req_i,
  input  logic [BOOT_W-1:0] boot_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              cold_rst_o,
  output logic              warm_rst_o,
  output logic              tst_rst_o,
  output logic              rstout_o,
  output logic              rstout_oe_o,
  output logic [BOOT_W-1:0] boot_mode_o
);
  logic                 swc_req, sww_req;
  logic [NUM_CAUSE-1:1] req_vec;
  logic                 arb_vld;
  cause_e               arb_cause;
  logic                 busy, accept, done;
  cause_e               cur_cause;
  dom_t                 dom;
  logic [BOOT_W-1:0]    boot_q;

  assign req_vec = {sww_req, swc_req, wdt_req_i, emu_req_i, pin_req_i, test_req_i};

  rstm_arb u_arb (
    .req_i   (req_vec),
    .vld_o   (arb_vld),
    .cause_o (arb_cause)
  );

  rstm_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld_i   (arb_vld),
    .req_cause_i (arb_cause),
    .busy_o      (busy),
    .cause_o     (cur_cause),
    .accept_o    (accept),
    .done_o      (done)
  );

  rstm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .accept_i  (accept),
    .cause_i   (arb_cause),
    .swc_req_o (swc_req),
    .sww_req_o (sww_req)
  );

  assign dom = domains_of(cur_cause);

  // Boot word is resampled only when a relatching sequence really ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 boot_q <= '0;
    else if (done && dom.relatch) boot_q <= boot_i;
  end

  assign cold_rst_o  = busy && dom.cold;
  assign warm_rst_o  = busy && dom.warm;
  assign tst_rst_o   = busy && dom.tst;
  assign rstout_oe_o = busy && !dom.pin_hiz;
  assign rstout_o    = boot_q[RSTOUT_BIT];
  assign boot_mode_o = boot_q;
endmodule

// File: rtl/sys_rst_mgr_chk.sv
module sys_rst_mgr_chk #(
  parameter int HOLD_CYC   = 16,
  parameter int BOOT_W     = 16,
  parameter int REGW       = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cold_rst_o,
  input logic              warm_rst_o,
  input logic              tst_rst_o,
  input logic              rstout_oe_o,
  input logic [BOOT_W-1:0] boot_mode_o,
  input logic              reg_wr_i,
  input logic              reg_addr_i,
  input logic [REGW-1:0]   reg_rdata_o
);
  logic       any_rst;
  logic [7:0] run_len;

  assign any_rst = cold_rst_o || warm_rst_o || tst_rst_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_len <= '0;
    else if (!any_rst)      run_len <= '0;
    else if (run_len != '1) run_len <= run_len + 1'b1;
  end

  // R2: test-only reset never touches the warm domain
  a_r2_test_only: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_rst_o && !cold_rst_o) |-> !warm_rst_o);

  // R3: a reset pulse is never shorter than the hold time
  a_r3_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_rst) |-> (run_len >= 8'(HOLD_CYC)));

  // R4: control bits read nonzero only right after a control write
  a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_addr_i && reg_rdata_o != '0) |-> $past(reg_wr_i && !reg_addr_i));

  // R5: boot word changes only at the end of a released-pin warm reset
  a_r5_boot_relatch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(boot_mode_o) |-> ($past(warm_rst_o) && $past(!rstout_oe_o) && !any_rst));

  // R6: reset-out is driven only inside a warm-domain reset
  a_r6_oe_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rstout_oe_o |-> warm_rst_o);
endmodule

bind sys_rst_mgr sys_rst_mgr_chk #(
  .HOLD_CYC (HOLD_CYC),
  .BOOT_W   (BOOT_W),
  .REGW     (rstm_pkg::REG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cold_rst_o  (cold_rst_o),
  .warm_rst_o  (warm_rst_o),
  .tst_rst_o   (tst_rst_o),
  .rstout_oe_o (rstout_oe_o),
  .boot_mode_o (boot_mode_o),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/sys_rst_mgr_tb_top.sv
`timescale 1ns/1ps
module sys_rst_mgr_tb_top;
  localparam int HOLD = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        test_req, pin_req, emu_req, wdt_req;
  logic [15:0] boot;
  logic        reg_wr, reg_addr;
  logic [6:0]  reg_wdata, reg_rdata;
  logic        cold_rst, warm_rst, tst_rst, rstout, rstout_oe;
  logic [15:0] boot_mode;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  sys_rst_mgr dut_i (
    .clk (clk), .rst_n (rst_n),
    .test_req_i (test_req), .pin_req_i (pin_req), .emu_req_i (emu_req), .wdt_req_i (wdt_req),
    .boot_i (boot), .reg_wr_i (reg_wr), .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata), .cold_rst_o (cold_rst), .warm_rst_o (warm_rst), .tst_rst_o (tst_rst),
    .rstout_o (rstout), .rstout_oe_o (rstout_oe), .boot_mode_o (boot_mode)
  );

  // {req test,pin,emu,wdt,swc,sww}, {expected status}, {cold,warm,tst,oe}
  localparam logic [16:0] VEC_TBL [8] = '{
    17'b000010_0100000_1101,
    17'b000001_1000000_0101,
    17'b000110_0010000_0101,
    17'b001101_0001000_0101,
    17'b011010_0000100_0100,
    17'b110100_0000010_0010,
    17'b000011_0100000_1101,
    17'b111111_0000010_0010
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [6:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [3:0] outs();
    return {cold_rst, warm_rst, tst_rst, rstout_oe};
  endfunction

  // Clears status, stages software bits, pulses hardware lines; returns at the
  // negedge right after the accepting edge.
  task automatic fire(input logic [5:0] req);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 7'h7F;
    @(negedge clk);
    reg_addr = 1'b0; reg_wdata = {5'b0, req[0], req[1]};
    @(negedge clk);
    reg_wr = 1'b0;
    {test_req, pin_req, emu_req, wdt_req} = req[5:2];
    @(negedge clk);
    {test_req, pin_req, emu_req, wdt_req} = 4'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [6:0] rv;
    rst_n = 1'b0; boot = 16'h0800;
    {test_req, pin_req, emu_req, wdt_req} = 4'b0;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R2 power-on domains", 32'(outs()), 32'b1110);
    rd(1'b1, rv); chk("R8 status under power-on", 32'(rv), 32'h01);
    rst_n = 1'b1;
    repeat (15) @(negedge clk);
    chk("R3 power-on still held at cycle 15", 32'(outs()), 32'b1110);
    @(negedge clk);
    chk("R3 power-on released at cycle 16", 32'(outs()), 32'b0000);
    chk("R5 boot latched at power-on release", 32'(boot_mode), 32'h0800);

    // Table walk: priority and domain selection.
    for (int v = 0; v < 8; v++) begin
      logic [16:0] e;
      e = VEC_TBL[v];
      fire(e[16:11]);
      rd(1'b1, rv); chk($sformatf("R1/R7 vec%0d status", v), 32'(rv), 32'(e[10:4]));
      chk($sformatf("R2 vec%0d domains", v), 32'(outs()), 32'(e[3:0]));
      if (e[0]) chk($sformatf("R6 vec%0d rstout level", v), 32'(rstout), 32'h1);
      repeat (15) @(negedge clk);
      chk($sformatf("R3 vec%0d held last cycle", v), 32'(outs()), 32'(e[3:0]));
      @(negedge clk);
      chk($sformatf("R3 vec%0d released", v), 32'(outs()), 32'b0000);
      repeat (2) @(negedge clk);
    end

    // Software warm keeps the boot word; control reads back 0.
    boot = 16'h1234;
    fire(6'b000001);
    rd(1'b0, rv); chk("R4 control self-cleared", 32'(rv), 32'h0);
    repeat (20) @(negedge clk);
    chk("R5 sw warm keeps boot word", 32'(boot_mode), 32'h0800);

    // Pin reset: released pin and relatch.
    fire(6'b010000);
    chk("R6 pin reset leaves pin undriven", 32'(rstout_oe), 32'h0);
    repeat (20) @(negedge clk);
    chk("R5 pin reset relatches boot word", 32'(boot_mode), 32'h1234);
    fire(6'b000001);
    chk("R6 driven level follows new bit 11", 32'({rstout_oe, rstout}), 32'b10);
    repeat (20) @(negedge clk);

    // Lower-ranked requests during a running emulation reset are dropped.
    fire(6'b001000);
    repeat (3) @(negedge clk);
    wdt_req = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 7'h01;
    @(negedge clk);
    wdt_req = 1'b0; reg_wr = 1'b0;
    repeat (11) @(negedge clk);
    chk("R9 original hold kept", 32'(outs()), 32'b0101);
    @(negedge clk);
    chk("R9 release unchanged", 32'(outs()), 32'b0000);
    rd(1'b1, rv); chk("R9 no status from dropped requests", 32'(rv), 32'h08);
    repeat (3) @(negedge clk);

    // Higher-ranked test request takes over a watchdog reset.
    fire(6'b000100);
    repeat (4) @(negedge clk);
    test_req = 1'b1;
    @(negedge clk);
    test_req = 1'b0;
    chk("R10 takeover domains", 32'(outs()), 32'b0010);
    rd(1'b1, rv); chk("R10 both causes recorded", 32'(rv), 32'h12);
    repeat (15) @(negedge clk);
    chk("R10 held 16 from takeover", 32'(outs()), 32'b0010);
    @(negedge clk);
    chk("R10 released after new hold", 32'(outs()), 32'b0000);

    // Write-one-to-clear status.
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 7'h02;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(1'b1, rv); chk("R7 clear one bit", 32'(rv), 32'h10);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 7'h00;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(1'b1, rv); chk("R7 writing zero keeps bits", 32'(rv), 32'h10);

    // Power-on wipes other cause bits.
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rd(1'b1, rv); chk("R8 power-on leaves only bit 0", 32'(rv), 32'h01);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R3 released after second power-on", 32'(outs()), 32'b0000);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule